// File: doc/BRIEF.md
# Periodic Up-Count Timer with Trigger Output

The block is a 16-bit counter that climbs from zero to a programmable limit and then wraps back to zero, over and over. Loading the limit register with N-1 yields a period of N counter steps. A second compare register places a rising edge inside each period. The trigger output goes high when the count arrives at that second value and drops when the count arrives at the limit. The result is a short pulse late in each period, suitable for starting another peripheral such as a converter without software.

The counter advances only on enable strobes from one of two tick sources, a fast one and a slow one, chosen by a select input. Clock generation stays outside the block. A run input switches between stopped and counting. When the count arrives at the limit and interrupts are enabled, a sticky flag is raised. Software clears the flag with a clear strobe.

Top module: `periodic_trigger_timer`

## Requirements
- R1: While `rst` is high at a clock edge, the count, the trigger output, the flag and both compare registers become zero.
- R2: With `run_up` high and the selected tick high, the count increases by one on each clock edge, as long as the present count differs from the limit register.
- R3: On a tick where the present count equals the limit register, the count becomes zero, so a limit of N-1 gives a period of N ticks. A new limit written through `lim_we` applies from the following cycle.
- R4: `tick_sel` = 0 selects `fast_tick` and `tick_sel` = 1 selects `slow_tick`. The unselected strobe has no effect on the count.
- R5: With `run_up` low, the count and the trigger output keep their values.
- R6: On a tick that moves the count to the value of the mark register (written through `mark_we`), the trigger output goes high.
- R7: On a tick that moves the count to the limit value, the trigger output goes low. This takes priority over R6 when both registers hold the same value.
- R8: On a tick that moves the count to the limit value with `irq_en` high, `irq_flag` becomes 1. With `irq_en` low, no such set occurs.
- R9: `irq_flag` stays at 1 until a cycle with `flag_clr` high and no set event, which clears it to 0.
- R10: When a set event from R8 and `flag_clr` fall in the same cycle, the flag ends at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fast_tick | input | 1 | Count enable strobe from the fast source |
| slow_tick | input | 1 | Count enable strobe from the slow source |
| tick_sel | input | 1 | 0 = fast source, 1 = slow source |
| run_up | input | 1 | 1 = count up, 0 = stopped |
| lim_we | input | 1 | Write `cmp_wdata` into the limit register |
| mark_we | input | 1 | Write `cmp_wdata` into the mark register |
| cmp_wdata | input | 16 | Compare write data |
| irq_en | input | 1 | Allows the limit match to set the flag |
| flag_clr | input | 1 | Clears the interrupt flag |
| count_o | output | 16 | Current count |
| trig_o | output | 1 | Set/reset trigger waveform |
| irq_flag | output | 1 | Sticky limit-match flag |

## Verification
A counter that takes a wrong next value shows up on `count_o` at the very next edge, and a failure to wrap shifts every later flag and trigger edge. A trigger register that latches the wrong level stays wrong until the next mark or limit match, so it is visible within one period. The table is therefore built so that each match event is checked in the cycle it takes effect. A flag that loses priority against the clear strobe shows 0 one cycle after a coincident match, and a dedicated vector checks exactly this.

// File: rtl/ptt_pkg.sv
package ptt_pkg;
  localparam int unsigned PTT_CMP_CH = 2;

  typedef enum logic [1:0] {
    ACT_HOLD  = 2'd0,
    ACT_SET   = 2'd1,
    ACT_CLEAR = 2'd2
  } out_act_e;
endpackage

// File: rtl/ptt_tick_sel.sv
module ptt_tick_sel (
  input  logic fast_tick,
  input  logic slow_tick,
  input  logic tick_sel,
  input  logic run_up,
  output logic adv
);
  logic src_tick;

  always_comb begin
    src_tick = tick_sel ? slow_tick : fast_tick;
    adv      = run_up & src_tick;
  end
endmodule

// File: rtl/ptt_compare_bank.sv
module ptt_compare_bank #(
  parameter int unsigned W   = 16,
  parameter int unsigned NCH = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] we,
  input  logic [W-1:0]   wdata,
  input  logic [W-1:0]   probe,
  output logic [NCH-1:0] hit,
  output logic [W-1:0]   lim_o
);
  logic [W-1:0] cmp_q [NCH];

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    always_ff @(posedge clk) begin
      if (rst) begin
        cmp_q[g] <= '0;
      end else if (we[g]) begin
        cmp_q[g] <= wdata;
      end
    end
    assign hit[g] = (probe == cmp_q[g]);
  end

  assign lim_o = cmp_q[0];
endmodule

// File: rtl/ptt_counter.sv
module ptt_counter #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         adv,
  input  logic [W-1:0] lim,
  output logic [W-1:0] cnt_q,
  output logic [W-1:0] cnt_nxt
);
  localparam logic [W-1:0] ONE = W'(1);

  always_comb begin
    if (cnt_q == lim) begin
      cnt_nxt = '0;
    end else begin
      cnt_nxt = cnt_q + ONE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (adv) begin
      cnt_q <= cnt_nxt;
    end
  end
endmodule

// File: rtl/ptt_out_unit.sv
module ptt_out_unit
  import ptt_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic adv,
  input  logic hit_lim,
  input  logic hit_mark,
  input  logic irq_en,
  input  logic flag_clr,
  output logic trig_q,
  output logic flag_q
);
  out_act_e act;
  logic     flag_set;

  always_comb begin
    act = ACT_HOLD;
    if (adv) begin
      if (hit_lim) begin
        act = ACT_CLEAR;
      end else if (hit_mark) begin
        act = ACT_SET;
      end
    end
    flag_set = adv & hit_lim & irq_en;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      trig_q <= 1'b0;
    end else begin
      unique case (act)
        ACT_SET:   trig_q <= 1'b1;
        ACT_CLEAR: trig_q <= 1'b0;
        default:   trig_q <= trig_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= 1'b0;
    end else if (flag_set) begin
      flag_q <= 1'b1;
    end else if (flag_clr) begin
      flag_q <= 1'b0;
    end
  end
endmodule

// File: rtl/periodic_trigger_timer.sv
module periodic_trigger_timer
  import ptt_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fast_tick,
  input  logic             slow_tick,
  input  logic             tick_sel,
  input  logic             run_up,
  input  logic             lim_we,
  input  logic             mark_we,
  input  logic [CNT_W-1:0] cmp_wdata,
  input  logic             irq_en,
  input  logic             flag_clr,
  output logic [CNT_W-1:0] count_o,
  output logic             trig_o,
  output logic             irq_flag
);
  logic                  adv;
  logic [CNT_W-1:0]      cnt_q;
  logic [CNT_W-1:0]      cnt_nxt;
  logic [CNT_W-1:0]      lim_q;
  logic [PTT_CMP_CH-1:0] hit;

  ptt_tick_sel u_tick (
    .fast_tick (fast_tick),
    .slow_tick (slow_tick),
    .tick_sel  (tick_sel),
    .run_up    (run_up),
    .adv       (adv)
  );

  ptt_compare_bank #(.W(CNT_W), .NCH(PTT_CMP_CH)) u_cmp (
    .clk   (clk),
    .rst   (rst),
    .we    ({mark_we, lim_we}),
    .wdata (cmp_wdata),
    .probe (cnt_nxt),
    .hit   (hit),
    .lim_o (lim_q)
  );

  ptt_counter #(.W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .adv     (adv),
    .lim     (lim_q),
    .cnt_q   (cnt_q),
    .cnt_nxt (cnt_nxt)
  );

  ptt_out_unit u_out (
    .clk      (clk),
    .rst      (rst),
    .adv      (adv),
    .hit_lim  (hit[0]),
    .hit_mark (hit[1]),
    .irq_en   (irq_en),
    .flag_clr (flag_clr),
    .trig_q   (trig_o),
    .flag_q   (irq_flag)
  );

  assign count_o = cnt_q;
endmodule

// File: rtl/ptt_checker.sv
module ptt_checker #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             fast_tick,
  input logic             slow_tick,
  input logic             tick_sel,
  input logic             run_up,
  input logic             irq_en,
  input logic             flag_clr,
  input logic [CNT_W-1:0] count_o,
  input logic             trig_o,
  input logic             irq_flag,
  input logic [CNT_W-1:0] lim
);
  logic go;
  assign go = run_up & (tick_sel ? slow_tick : fast_tick);

  AST_STOP_HOLD: assert property (@(posedge clk) disable iff (rst)
    !run_up |=> ($stable(count_o) && $stable(trig_o))); // R5

  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (rst)
    (go && count_o == lim) |=> (count_o == '0)); // R3

  AST_STEP_ONE: assert property (@(posedge clk) disable iff (rst)
    (go && count_o != lim) |=> (count_o == $past(count_o) + CNT_W'(1))); // R2

  AST_LIM_DROPS_TRIG: assert property (@(posedge clk) disable iff (rst)
    (go && count_o != lim && count_o + CNT_W'(1) == lim) |=> !trig_o); // R7

  AST_LIM_SETS_FLAG: assert property (@(posedge clk) disable iff (rst)
    (go && irq_en && count_o != lim && count_o + CNT_W'(1) == lim) |=> irq_flag); // R10

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    (irq_flag && !flag_clr) |=> irq_flag); // R9
endmodule

bind periodic_trigger_timer ptt_checker #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .fast_tick (fast_tick),
  .slow_tick (slow_tick),
  .tick_sel  (tick_sel),
  .run_up    (run_up),
  .irq_en    (irq_en),
  .flag_clr  (flag_clr),
  .count_o   (count_o),
  .trig_o    (trig_o),
  .irq_flag  (irq_flag),
  .lim       (lim_q)
);

// File: tb/tb_periodic_trigger_timer.sv
module tb_periodic_trigger_timer;
  localparam int CLK_PERIOD = 10;
  localparam int W = 16;
  localparam int NVEC = 18;
  localparam int WATCHDOG = 5000;

  // {run_up, fast_tick, slow_tick, tick_sel, flag_clr, count[15:0], trig, flag}
  localparam logic [22:0] VEC [NVEC] = '{
    {5'b11000, 16'd1, 2'b00},  // R2
    {5'b11000, 16'd2, 2'b10},  // R6
    {5'b11000, 16'd3, 2'b10},  // R2
    {5'b11000, 16'd4, 2'b01},  // R7 R8
    {5'b11000, 16'd0, 2'b01},  // R3
    {5'b10000, 16'd0, 2'b01},  // R4 no tick
    {5'b11001, 16'd1, 2'b00},  // R9
    {5'b01000, 16'd1, 2'b00},  // R5
    {5'b11010, 16'd1, 2'b00},  // R4 fast ignored
    {5'b10110, 16'd2, 2'b10},  // R4 slow used
    {5'b00110, 16'd2, 2'b10},  // R5 trig held
    {5'b11000, 16'd3, 2'b10},
    {5'b11000, 16'd4, 2'b01},  // R7 R8
    {5'b11001, 16'd0, 2'b00},  // R9
    {5'b11000, 16'd1, 2'b00},
    {5'b11000, 16'd2, 2'b10},
    {5'b11000, 16'd3, 2'b10},
    {5'b11001, 16'd4, 2'b01}   // R10
  };

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         fast_tick = 1'b0, slow_tick = 1'b0, tick_sel = 1'b0, run_up = 1'b0;
  logic         lim_we = 1'b0, mark_we = 1'b0, irq_en = 1'b0, flag_clr = 1'b0;
  logic [W-1:0] cmp_wdata = '0;
  logic [W-1:0] count_o;
  logic         trig_o, irq_flag;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  periodic_trigger_timer #(.CNT_W(W)) dut (
    .clk(clk), .rst(rst), .fast_tick(fast_tick), .slow_tick(slow_tick),
    .tick_sel(tick_sel), .run_up(run_up), .lim_we(lim_we), .mark_we(mark_we),
    .cmp_wdata(cmp_wdata), .irq_en(irq_en), .flag_clr(flag_clr),
    .count_o(count_o), .trig_o(trig_o), .irq_flag(irq_flag)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic check_all(input string req, input int c, input int t, input int f);
    check(req, "count", int'(count_o), c);
    check(req, "trig", int'(trig_o), t);
    check(req, "flag", int'(irq_flag), f);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=expired expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_all("R1", 0, 0, 0);
    rst = 1'b0;
    lim_we = 1'b1; cmp_wdata = 16'd4;
    @(negedge clk);
    lim_we = 1'b0; mark_we = 1'b1; cmp_wdata = 16'd2;
    @(negedge clk);
    mark_we = 1'b0; irq_en = 1'b1;
    check_all("R1", 0, 0, 0);

    for (int i = 0; i < NVEC; i++) begin
      {run_up, fast_tick, slow_tick, tick_sel, flag_clr} = VEC[i][22:18];
      @(negedge clk);
      check_all($sformatf("R2-table vec%0d", i), int'(VEC[i][17:2]),
                int'(VEC[i][1]), int'(VEC[i][0]));
    end

    // R9: clear while stopped; R8: flag disabled
    {run_up, fast_tick, slow_tick, tick_sel, flag_clr} = 5'b01001;
    @(negedge clk);
    check("R9", "flag", int'(irq_flag), 0);
    flag_clr = 1'b0; irq_en = 1'b0;
    lim_we = 1'b1; cmp_wdata = 16'd9;
    @(negedge clk);
    lim_we = 1'b0; run_up = 1'b1;
    repeat (5) @(negedge clk);
    check("R3", "count at new limit", int'(count_o), 9);
    check("R8", "flag with irq_en low", int'(irq_flag), 0);
    check("R7", "trig", int'(trig_o), 0);
    @(negedge clk);
    check("R3", "wrap from 9", int'(count_o), 0);
    repeat (9) @(negedge clk);
    check("R3", "count before wrap", int'(count_o), 9);
    @(negedge clk);
    check("R3", "period of 10", int'(count_o), 0);

    // R7: mark equal to limit, clear wins
    mark_we = 1'b1; cmp_wdata = 16'd9;
    @(negedge clk);
    mark_we = 1'b0;
    repeat (8) @(negedge clk);
    check("R7", "count", int'(count_o), 9);
    check("R7", "trig with mark==limit", int'(trig_o), 0);

    // R1: reset mid-run
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0; run_up = 1'b0;
    check_all("R1", 0, 0, 0);
    run_up = 1'b1;
    @(negedge clk);
    check("R1", "limit cleared by reset", int'(count_o), 0);
    finish_run();
  end
endmodule